// File: doc/BRIEF.md
# Split Execution Sub-Pipeline with Shared Write-Back

This block is the back end of an in-order integer core. Each cycle it may accept one issued instruction, already decoded and with its operands read. The instruction carries an operation class, a function code, up to three source operands, a shift amount and a destination register number. The class picks one of three parallel lanes, and each lane is three register stages deep. The integer lane shifts the second operand, then combines it with the first, then clamps signed overflow. The multiply lane builds a product in two half-width partial steps and can add an accumulator in its third step. The memory lane forms a word address, reads a small internal data store, and commits stores in its last step.

Every lane has the same depth, so at most one result reaches the write-back register in any cycle. A single register-file write port leaves the block, together with a sticky flag that records whether any integer result was ever clamped. Slots without a valid instruction travel through the lanes as bubbles. Stores, reserved classes and bubbles never produce a write.

Top module: `xsplit_exec`

## Requirements
- R1: After reset the block drives wb_en=0 and sat_sticky=0, and every word of the internal data store reads as zero.
- R2: An instruction sampled with iss_valid=1 on rising edge n that produces a result drives wb_en=1 with wb_addr=iss_dst after edge n+3, for exactly one cycle. A slot sampled with iss_valid=0 produces no write-back.
- R3: The class encoding is 0 for integer, 1 for multiply and 2 for memory. Class 3 is reserved: it is dropped and never produces a write-back.
- R4: For an integer op, the low two bits of iss_func select how iss_b is shifted by iss_shamt (0 to 31) before the arithmetic step: 0 none, 1 logical left, 2 logical right, 3 arithmetic right.
- R5: For an integer op, bits 3:2 of iss_func select the arithmetic step on iss_a and the shifted operand: 0 add, 1 subtract (iss_a minus shifted), 2 bitwise AND, 3 bitwise XOR.
- R6: A signed overflow of add or subtract writes 0x7FFFFFFF when the true result is positive and 0x80000000 when it is negative. AND and XOR are never clamped.
- R7: sat_sticky becomes 1 after the same edge that writes back a clamped result, and stays 1 until reset.
- R8: For a multiply op, iss_func[0]=0 writes the low 32 bits of iss_a*iss_b. iss_func[0]=1 writes the low 32 bits of iss_a*iss_b+iss_c.
- R9: For a memory op, the word index is (iss_a+iss_b) modulo the store depth. iss_func[0]=0 is a load that writes the addressed word back; iss_func[0]=1 is a store of iss_c that writes the store and produces no write-back.
- R10: A load issued in the cycle right after a store to the same word returns the stored data.
- R11: Instructions of any class may be issued back to back every cycle, and their results leave in issue order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented this cycle |
| iss_class | input | 2 | Lane select: 0 integer, 1 multiply, 2 memory, 3 reserved |
| iss_func | input | 4 | Function code, interpreted per class |
| iss_shamt | input | 5 | Shift amount for the integer lane |
| iss_dst | input | 5 | Destination register number |
| iss_a | input | 32 | First source operand |
| iss_b | input | 32 | Second source operand |
| iss_c | input | 32 | Accumulator addend or store data |
| wb_en | output | 1 | Register-file write enable |
| wb_addr | output | 5 | Register-file write address |
| wb_data | output | 32 | Register-file write data |
| sat_sticky | output | 1 | Set once any integer result has been clamped |

## Verification
Every lane is three registers deep, and the write-back register follows them. A result whose instruction was sampled on edge n is therefore due after edge n+3, and the sticky flag moves on that same edge. The bench drives on falling edges and keeps a four-entry line of expected outcomes that shifts once per falling edge. Each output is compared four falling edges after its stimulus, half a cycle after the edge that made it, and an empty entry checks that wb_en stays low. The directed sticky test samples the flag one falling edge before and one after the due edge, which shows it rises on exactly that edge.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;
    localparam int SHW  = $clog2(XLEN);
    localparam int FW   = 4;
    localparam int HALF = XLEN / 2;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_MAC = 2'd1,
        CLS_LSU = 2'd2,
        CLS_RSV = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_LSL  = 2'd1,
        SH_LSR  = 2'd2,
        SH_ASR  = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        AR_ADD = 2'd0,
        AR_SUB = 2'd1,
        AR_AND = 2'd2,
        AR_XOR = 2'd3
    } arith_e;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic [XLEN-1:0] data;
    } lane_res_t;

endpackage

// File: rtl/xsp_alu_lane.sv
module xsp_alu_lane
    import xsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [FW-1:0]   in_func,
    input  logic [SHW-1:0]  in_shamt,
    input  logic [RAW-1:0]  in_dst,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output lane_res_t       out_res,
    output logic            out_sat
);

    localparam logic [XLEN-1:0] SAT_MAX = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] SAT_MIN = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        arith_e          op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } shf_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic [XLEN-1:0] res;
        logic            ovf;
        logic            neg;
    } ari_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic [XLEN-1:0] res;
        logic            sat;
    } clp_st_t;

    typedef struct packed {
        shf_st_t shf;
        ari_st_t ari;
        clp_st_t clp;
    } alu_st_t;

    alu_st_t         st_d, st_q;
    shift_e          sh_kind;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            a_msb;
    logic            b_msb;

    always_comb begin
        st_d    = st_q;
        sh_kind = shift_e'(in_func[1:0]);

        // shift step
        case (sh_kind)
            SH_LSL:  shifted = in_b << in_shamt;
            SH_LSR:  shifted = in_b >> in_shamt;
            SH_ASR:  shifted = $signed(in_b) >>> in_shamt;
            default: shifted = in_b;
        endcase
        st_d.shf.valid = in_valid;
        st_d.shf.dst   = in_dst;
        st_d.shf.op    = arith_e'(in_func[3:2]);
        st_d.shf.a     = in_a;
        st_d.shf.b     = shifted;

        // arithmetic / logic step
        sum   = st_q.shf.a + st_q.shf.b;
        diff  = st_q.shf.a - st_q.shf.b;
        a_msb = st_q.shf.a[XLEN-1];
        b_msb = st_q.shf.b[XLEN-1];
        st_d.ari.valid = st_q.shf.valid;
        st_d.ari.dst   = st_q.shf.dst;
        st_d.ari.neg   = a_msb;
        case (st_q.shf.op)
            AR_ADD: begin
                st_d.ari.res = sum;
                st_d.ari.ovf = (a_msb == b_msb) && (sum[XLEN-1] != a_msb);
            end
            AR_SUB: begin
                st_d.ari.res = diff;
                st_d.ari.ovf = (a_msb != b_msb) && (diff[XLEN-1] != a_msb);
            end
            AR_AND: begin
                st_d.ari.res = st_q.shf.a & st_q.shf.b;
                st_d.ari.ovf = 1'b0;
            end
            default: begin
                st_d.ari.res = st_q.shf.a ^ st_q.shf.b;
                st_d.ari.ovf = 1'b0;
            end
        endcase

        // saturation step
        st_d.clp.valid = st_q.ari.valid;
        st_d.clp.dst   = st_q.ari.dst;
        st_d.clp.sat   = st_q.ari.valid && st_q.ari.ovf;
        if (st_q.ari.ovf) begin
            st_d.clp.res = st_q.ari.neg ? SAT_MIN : SAT_MAX;
        end else begin
            st_d.clp.res = st_q.ari.res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_res.valid = st_q.clp.valid;
    assign out_res.dst   = st_q.clp.dst;
    assign out_res.data  = st_q.clp.res;
    assign out_sat       = st_q.clp.sat;

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clp.valid && st_q.clp.sat) |-> (st_q.clp.res == SAT_MAX || st_q.clp.res == SAT_MIN)); // R6

    AST_LOGIC_UNCLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shf.valid && (st_q.shf.op == AR_AND || st_q.shf.op == AR_XOR)) |=> !st_q.ari.ovf); // R6

endmodule

// File: rtl/xsp_mac_lane.sv
module xsp_mac_lane
    import xsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_acc,
    input  logic [RAW-1:0]  in_dst,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_c,
    output lane_res_t       out_res
);

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic            acc;
        logic [XLEN-1:0] c;
        logic [HALF-1:0] a_hi;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] part;
    } m1_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic            acc;
        logic [XLEN-1:0] c;
        logic [XLEN-1:0] part;
    } m2_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic [XLEN-1:0] res;
    } m3_st_t;

    typedef struct packed {
        m1_st_t m1;
        m2_st_t m2;
        m3_st_t m3;
    } mac_st_t;

    mac_st_t         st_d, st_q;
    logic [XLEN-1:0] lo_prod;
    logic [XLEN-1:0] hi_prod;

    always_comb begin
        st_d = st_q;

        // step 1: low half of the first operand times the second
        lo_prod = {{HALF{1'b0}}, in_a[HALF-1:0]} * in_b;
        st_d.m1.valid = in_valid;
        st_d.m1.dst   = in_dst;
        st_d.m1.acc   = in_acc;
        st_d.m1.c     = in_c;
        st_d.m1.a_hi  = in_a[XLEN-1:HALF];
        st_d.m1.b     = in_b;
        st_d.m1.part  = lo_prod;

        // step 2: add the high half contribution
        hi_prod = {{HALF{1'b0}}, st_q.m1.a_hi} * st_q.m1.b;
        st_d.m2.valid = st_q.m1.valid;
        st_d.m2.dst   = st_q.m1.dst;
        st_d.m2.acc   = st_q.m1.acc;
        st_d.m2.c     = st_q.m1.c;
        st_d.m2.part  = st_q.m1.part + {hi_prod[HALF-1:0], {HALF{1'b0}}};

        // step 3: optional accumulate
        st_d.m3.valid = st_q.m2.valid;
        st_d.m3.dst   = st_q.m2.dst;
        st_d.m3.res   = st_q.m2.part + (st_q.m2.acc ? st_q.m2.c : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_res.valid = st_q.m3.valid;
    assign out_res.dst   = st_q.m3.dst;
    assign out_res.data  = st_q.m3.res;

    AST_MAC_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m2.valid && !st_q.m2.acc) |=> (st_q.m3.res == $past(st_q.m2.part))); // R8

endmodule

// File: rtl/xsp_lsu_lane.sv
module xsp_lsu_lane
    import xsp_pkg::*;
#(
    parameter int MEM_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_store,
    input  logic [RAW-1:0]               in_dst,
    input  logic [$clog2(MEM_WORDS)-1:0] in_a,
    input  logic [$clog2(MEM_WORDS)-1:0] in_b,
    input  logic [XLEN-1:0]              in_c,
    output lane_res_t                    out_res
);

    localparam int IDXW = $clog2(MEM_WORDS);

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic            store;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] sdata;
    } ag_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic            store;
        logic [IDXW-1:0] idx;
        logic [XLEN-1:0] sdata;
        logic [XLEN-1:0] ldata;
    } d1_st_t;

    typedef struct packed {
        logic            valid;
        logic [RAW-1:0]  dst;
        logic [XLEN-1:0] data;
    } d2_st_t;

    typedef struct packed {
        ag_st_t ag;
        d1_st_t d1;
        d2_st_t d2;
    } lsu_st_t;

    lsu_st_t         st_d, st_q;
    logic [XLEN-1:0] mem_q [MEM_WORDS];
    logic            fwd_hit;

    always_comb begin
        st_d = st_q;

        // address generation
        st_d.ag.valid = in_valid;
        st_d.ag.dst   = in_dst;
        st_d.ag.store = in_store;
        st_d.ag.idx   = in_a + in_b;
        st_d.ag.sdata = in_c;

        // first access step: read, bypassing a store still in flight
        fwd_hit = st_q.d1.valid && st_q.d1.store && (st_q.d1.idx == st_q.ag.idx);
        st_d.d1.valid = st_q.ag.valid;
        st_d.d1.dst   = st_q.ag.dst;
        st_d.d1.store = st_q.ag.store;
        st_d.d1.idx   = st_q.ag.idx;
        st_d.d1.sdata = st_q.ag.sdata;
        st_d.d1.ldata = fwd_hit ? st_q.d1.sdata : mem_q[st_q.ag.idx];

        // second access step: stores commit here and go silent
        st_d.d2.valid = st_q.d1.valid && !st_q.d1.store;
        st_d.d2.dst   = st_q.d1.dst;
        st_d.d2.data  = st_q.d1.ldata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (st_q.d1.valid && st_q.d1.store) begin
            mem_q[st_q.d1.idx] <= st_q.d1.sdata;
        end
    end

    assign out_res.valid = st_q.d2.valid;
    assign out_res.dst   = st_q.d2.dst;
    assign out_res.data  = st_q.d2.data;

    AST_STORE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.d1.valid && st_q.d1.store) |=> (mem_q[$past(st_q.d1.idx)] == $past(st_q.d1.sdata))); // R9

endmodule

// File: rtl/xsplit_exec.sv
module xsplit_exec
    import xsp_pkg::*;
#(
    parameter int MEM_WORDS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [1:0]      iss_class,
    input  logic [FW-1:0]   iss_func,
    input  logic [SHW-1:0]  iss_shamt,
    input  logic [RAW-1:0]  iss_dst,
    input  logic [XLEN-1:0] iss_a,
    input  logic [XLEN-1:0] iss_b,
    input  logic [XLEN-1:0] iss_c,
    output logic            wb_en,
    output logic [RAW-1:0]  wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            sat_sticky
);

    localparam int IDXW = $clog2(MEM_WORDS);

    typedef struct packed {
        logic            en;
        logic [RAW-1:0]  addr;
        logic [XLEN-1:0] data;
        logic            sticky;
    } wb_st_t;

    op_class_e cls;
    logic      alu_go, mac_go, lsu_go;
    lane_res_t alu_res, mac_res, lsu_res;
    logic      alu_sat;
    wb_st_t    wb_d, wb_q;

    assign cls    = op_class_e'(iss_class);
    assign alu_go = iss_valid && (cls == CLS_ALU);
    assign mac_go = iss_valid && (cls == CLS_MAC);
    assign lsu_go = iss_valid && (cls == CLS_LSU);

    xsp_alu_lane u_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (alu_go),
        .in_func  (iss_func),
        .in_shamt (iss_shamt),
        .in_dst   (iss_dst),
        .in_a     (iss_a),
        .in_b     (iss_b),
        .out_res  (alu_res),
        .out_sat  (alu_sat)
    );

    xsp_mac_lane u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (mac_go),
        .in_acc   (iss_func[0]),
        .in_dst   (iss_dst),
        .in_a     (iss_a),
        .in_b     (iss_b),
        .in_c     (iss_c),
        .out_res  (mac_res)
    );

    xsp_lsu_lane #(
        .MEM_WORDS (MEM_WORDS)
    ) u_lsu (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (lsu_go),
        .in_store (iss_func[0]),
        .in_dst   (iss_dst),
        .in_a     (iss_a[IDXW-1:0]),
        .in_b     (iss_b[IDXW-1:0]),
        .in_c     (iss_c),
        .out_res  (lsu_res)
    );

    always_comb begin
        wb_d        = wb_q;
        wb_d.en     = alu_res.valid || mac_res.valid || lsu_res.valid;
        wb_d.sticky = wb_q.sticky || (alu_res.valid && alu_sat);
        if (alu_res.valid) begin
            wb_d.addr = alu_res.dst;
            wb_d.data = alu_res.data;
        end else if (mac_res.valid) begin
            wb_d.addr = mac_res.dst;
            wb_d.data = mac_res.data;
        end else if (lsu_res.valid) begin
            wb_d.addr = lsu_res.dst;
            wb_d.data = lsu_res.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign wb_en      = wb_q.en;
    assign wb_addr    = wb_q.addr;
    assign wb_data    = wb_q.data;
    assign sat_sticky = wb_q.sticky;

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_res.valid, mac_res.valid, lsu_res.valid})); // R11

    AST_WB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ($past(iss_valid, 4) && (wb_addr == $past(iss_dst, 4)))); // R2

    AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ($past(iss_class, 4) != 2'd3)); // R3

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !($past(iss_class, 4) == 2'd2 && $past(iss_func[0], 4))); // R9

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky); // R7

endmodule

// File: tb/xsplit_exec_bench.sv
`timescale 1ns/1ps
module xsplit_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_class = '0;
    logic [3:0]  iss_func = '0;
    logic [4:0]  iss_shamt = '0;
    logic [4:0]  iss_dst = '0;
    logic [31:0] iss_a = '0;
    logic [31:0] iss_b = '0;
    logic [31:0] iss_c = '0;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [31:0] wb_data;
    logic        sat_sticky;

    always #2.5 clk = ~clk;

    xsplit_exec u_xsplit_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_class  (iss_class),
        .iss_func   (iss_func),
        .iss_shamt  (iss_shamt),
        .iss_dst    (iss_dst),
        .iss_a      (iss_a),
        .iss_b      (iss_b),
        .iss_c      (iss_c),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .sat_sticky (sat_sticky)
    );

    typedef struct packed {
        logic        vld;
        logic [1:0]  cls;
        logic [3:0]  func;
        logic [4:0]  sh;
        logic [4:0]  dst;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        een;
        logic [31:0] ed;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 4'h0, 5'd0,  5'd1,  32'd5,        32'd7,        32'd0,        1'b1, 32'd12,       8'd5},  // R5 add
        '{1'b1, 2'd0, 4'h4, 5'd0,  5'd2,  32'd10,       32'd3,        32'd0,        1'b1, 32'd7,        8'd5},  // R5 sub
        '{1'b1, 2'd0, 4'h8, 5'd0,  5'd3,  32'hF0F0F0F0, 32'hFF00FF00, 32'd0,        1'b1, 32'hF000F000, 8'd5},  // R5 and
        '{1'b1, 2'd0, 4'hC, 5'd0,  5'd4,  32'hFFFF0000, 32'h0F0F0F0F, 32'd0,        1'b1, 32'hF0F00F0F, 8'd5},  // R5 xor
        '{1'b1, 2'd0, 4'h1, 5'd4,  5'd5,  32'd0,        32'd1,        32'd0,        1'b1, 32'h10,       8'd4},  // R4 lsl
        '{1'b1, 2'd0, 4'h2, 5'd31, 5'd6,  32'd0,        32'h80000000, 32'd0,        1'b1, 32'd1,        8'd4},  // R4 lsr
        '{1'b1, 2'd0, 4'h3, 5'd4,  5'd7,  32'd0,        32'h80000000, 32'd0,        1'b1, 32'hF8000000, 8'd4},  // R4 asr
        '{1'b1, 2'd0, 4'h0, 5'd0,  5'd8,  32'h7FFFFFFF, 32'd1,        32'd0,        1'b1, 32'h7FFFFFFF, 8'd6},  // R6 add pos clamp
        '{1'b1, 2'd0, 4'h4, 5'd0,  5'd9,  32'h80000000, 32'd1,        32'd0,        1'b1, 32'h80000000, 8'd6},  // R6 sub neg clamp
        '{1'b1, 2'd0, 4'h0, 5'd0,  5'd10, 32'h80000000, 32'hFFFFFFFF, 32'd0,        1'b1, 32'h80000000, 8'd6},  // R6 add neg clamp
        '{1'b1, 2'd0, 4'hC, 5'd0,  5'd11, 32'h7FFFFFFF, 32'h80000000, 32'd0,        1'b1, 32'hFFFFFFFF, 8'd6},  // R6 logic not clamped
        '{1'b1, 2'd1, 4'h0, 5'd0,  5'd12, 32'd3,        32'd5,        32'd0,        1'b1, 32'd15,       8'd8},  // R8 multiply
        '{1'b1, 2'd1, 4'h0, 5'd0,  5'd13, 32'h00020003, 32'h10,       32'd0,        1'b1, 32'h00200030, 8'd8},  // R8 high half
        '{1'b1, 2'd1, 4'h1, 5'd0,  5'd14, 32'hFFFFFFFF, 32'd2,        32'd10,       1'b1, 32'd8,        8'd8},  // R8 accumulate
        '{1'b1, 2'd1, 4'h0, 5'd0,  5'd15, 32'h00010001, 32'h00010001, 32'd0,        1'b1, 32'h00020001, 8'd8},  // R8 wrap
        '{1'b1, 2'd2, 4'h1, 5'd0,  5'd31, 32'h100,      32'd2,        32'hCAFEBABE, 1'b0, 32'd0,        8'd9},  // R9 store word 2
        '{1'b1, 2'd2, 4'h0, 5'd0,  5'd16, 32'd2,        32'd0,        32'd0,        1'b1, 32'hCAFEBABE, 8'd10}, // R10 bypass
        '{1'b1, 2'd2, 4'h0, 5'd0,  5'd17, 32'd3,        32'd0,        32'd0,        1'b1, 32'd0,        8'd1},  // R1 untouched word
        '{1'b1, 2'd2, 4'h1, 5'd0,  5'd30, 32'd1,        32'd2,        32'h12345678, 1'b0, 32'd0,        8'd9},  // R9 store word 3
        '{1'b1, 2'd3, 4'h0, 5'd0,  5'd18, 32'd1,        32'd1,        32'd0,        1'b0, 32'd0,        8'd3},  // R3 reserved
        '{1'b1, 2'd2, 4'h0, 5'd0,  5'd19, 32'd3,        32'd0,        32'd0,        1'b1, 32'h12345678, 8'd9},  // R9 load after commit
        '{1'b0, 2'd0, 4'h0, 5'd0,  5'd20, 32'd1,        32'd1,        32'd0,        1'b0, 32'd0,        8'd2},  // R2 bubble
        '{1'b1, 2'd2, 4'h0, 5'd0,  5'd21, 32'h12,       32'd0,        32'd0,        1'b1, 32'hCAFEBABE, 8'd9},  // R9 index wraps
        '{1'b1, 2'd0, 4'h1, 5'd1,  5'd22, 32'd1,        32'd2,        32'd0,        1'b1, 32'd5,        8'd11}  // R11 shift+add
    };

    localparam vec_t IDLE = '{1'b0, 2'd0, 4'h0, 5'd0, 5'd0, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 8'd2};

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic        pv [4];
    logic [4:0]  pa [4];
    logic [31:0] pd [4];
    logic [7:0]  pr [4];

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_line();
        for (int i = 0; i < 4; i++) begin
            pv[i] = 1'b0; pa[i] = '0; pd[i] = '0; pr[i] = 8'd2;
        end
    endtask

    task automatic drive(input vec_t v);
        iss_valid = v.vld;
        iss_class = v.cls;
        iss_func  = v.func;
        iss_shamt = v.sh;
        iss_dst   = v.dst;
        iss_a     = v.a;
        iss_b     = v.b;
        iss_c     = v.c;
    endtask

    // one falling edge: check the result due now, then present the next slot
    task automatic step(input vec_t v);
        @(negedge clk);
        if (pv[3]) begin
            chk(pr[3], "wb_en",   {31'd0, wb_en}, 32'd1);
            chk(pr[3], "wb_addr", {27'd0, wb_addr}, {27'd0, pa[3]});
            chk(pr[3], "wb_data", wb_data, pd[3]);
        end else begin
            chk(pr[3], "no write-back", {31'd0, wb_en}, 32'd0);
        end
        for (int i = 3; i > 0; i--) begin
            pv[i] = pv[i-1]; pa[i] = pa[i-1]; pd[i] = pd[i-1]; pr[i] = pr[i-1];
        end
        pv[0] = v.een; pa[0] = v.dst; pd[0] = v.ed; pr[0] = v.req;
        drive(v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        drive(IDLE);
        clear_line();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(1, "wb_en in reset", {31'd0, wb_en}, 32'd0);           // R1
        chk(1, "sat_sticky in reset", {31'd0, sat_sticky}, 32'd0); // R1
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        vec_t sat_v;
        vec_t ld_v;
        clear_line();
        do_reset();

        // R11: the whole table goes in back to back, one slot per cycle
        for (int k = 0; k < NV; k++) begin
            step(VEC[k]);
        end
        repeat (5) step(IDLE);
        chk(7, "sticky after clamps", {31'd0, sat_sticky}, 32'd1); // R7

        // R1: reset clears the sticky flag and the data store
        do_reset();
        ld_v = '{1'b1, 2'd2, 4'h0, 5'd0, 5'd9, 32'd2, 32'd0, 32'd0, 1'b1, 32'd0, 8'd1}; // R1
        step(ld_v);
        repeat (4) step(IDLE);

        // R7: sticky rises on the edge that writes the clamped value
        sat_v = '{1'b1, 2'd0, 4'h0, 5'd0, 5'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, 1'b1, 32'h7FFFFFFF, 8'd7};
        step(sat_v);
        step(IDLE);
        step(IDLE);
        step(IDLE);
        chk(7, "sticky before due edge", {31'd0, sat_sticky}, 32'd0); // R7
        step(IDLE);
        chk(7, "sticky at due edge", {31'd0, sat_sticky}, 32'd1);     // R7
        repeat (5) step(IDLE);
        chk(7, "sticky held", {31'd0, sat_sticky}, 32'd1);            // R7

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            finish_run();
        end
    end

endmodule